// File: doc/BRIEF.md
# Upstream Read Data Framer

This block sits between the DRAM-side read path of a buffered memory module and the upstream lanes of its serial channel. It takes 144-bit read beats, each one a DRAM clock's worth of data with its check bits, and turns each beat into one frame that is spread across 14 lanes over 12 bit times. Each frame also carries an 8-bit header and a 16-bit CRC. Four beats make a 72-byte burst: 64 data bytes plus 8 check bytes.

Frames follow one another without a gap. When no beat is waiting at a frame boundary, the block sends an all-zero idle frame. Beats may arrive on any cycle. A beat that arrives while a frame is on the lanes waits in a two-entry queue. If the queue is already full, the beat is dropped and a sticky error flag is set. One clock cycle of the block is one bit time on the lanes.

Top module: `rd_upstream_framer`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `frm_start` is 1, `frm_idle` is 1, every lane bit is 0 and `ovf_err` is 0.
- R2: `frm_start` is high in exactly one cycle out of every 12, and that cycle is the first bit time of a frame.
- R3: Number the 168 frame bits [167:0]. Lane L at bit time t (t = 0..11) carries frame bit L*12+11-t, so each lane sends its 12-bit slice most-significant bit first.
- R4: The frame is laid out as follows. Bits [167:160] are the header, with the type in [167:166], the burst sequence number in [165:164] and zeros in [163:160]. Bits [159:16] are the 144-bit payload. Bits [15:0] are the CRC.
- R5: If no beat is waiting at a frame boundary, the next frame is all zero: type 00, zero payload and zero CRC. `frm_idle` is high for all 12 bit times of an idle frame and low for all 12 bit times of a data frame.
- R6: Accepted beats leave in the order they arrived, one per frame. The type is 01 for a beat flagged as burst start and 10 for any other beat.
- R7: The sequence number is 0 for a burst-start beat. For each following beat it is one more than for the previous sent beat, wrapping from 3 to 0.
- R8: The CRC uses the polynomial 0x1021 with an initial value of 0x0000 and no final inversion. It is computed over the payload, starting at bit 143 and ending at bit 0.
- R9: Up to two beats can wait behind the frame on the lanes. Two beats on consecutive cycles are both sent and leave `ovf_err` at 0.
- R10: A beat that arrives when two beats are already waiting, in a cycle where no beat leaves the queue, is dropped. `ovf_err` then goes to 1 and stays there until reset. The beats already waiting are still sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_vld | input | 1 | A read beat is present this cycle |
| beat_first | input | 1 | The beat starts a new burst |
| beat_data | input | 144 | Read beat payload including check bits |
| lane_bits | output | 14 | One serial bit per upstream lane |
| frm_start | output | 1 | First bit time of a frame |
| frm_idle | output | 1 | The frame now on the lanes is an idle frame |
| ovf_err | output | 1 | Sticky queue overflow flag |

## Verification
The assertions check the rules that hold on every cycle. The bit-time counter steps by one and wraps to a frame start. An idle frame drives zero on every lane, and a boundary with no beat waiting loads an all-zero frame. A burst-start beat loads sequence number 0 with the burst-start type. The queue never holds more than two entries, and the overflow flag, once set, never clears. Other behaviour can only be shown by the bench's scenarios. These are the exact lane mapping, the CRC value, the ordering of beats, the sequence wrap from 3 to 0, and which beat is lost when the queue overflows. The bench checks them by rebuilding each frame from the lane bits.

// File: rtl/rdu_pkg.sv
package rdu_pkg;
  localparam int LANES     = 14;
  localparam int BIT_TIMES = 12;
  localparam int FRAME_W   = LANES * BIT_TIMES;
  localparam int PAY_W     = 144;
  localparam int CRC_W     = 16;
  localparam int HDR_W     = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  typedef enum logic [1:0] {
    FT_IDLE = 2'b00,
    FT_HEAD = 2'b01,
    FT_BODY = 2'b10
  } frame_type_e;

  typedef struct packed {
    logic             first;
    logic [PAY_W-1:0] data;
  } beat_t;

  // Bit-serial CRC, MSB of the payload first, zero seed.
  function automatic logic [CRC_W-1:0] crc_payload(input logic [PAY_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '0;
    for (int i = PAY_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  function automatic logic [FRAME_W-1:0] pack_frame(input frame_type_e ft,
                                                    input logic [1:0] sq,
                                                    input logic [PAY_W-1:0] d);
    logic [HDR_W-1:0] hdr;
    hdr = {ft, sq, {(HDR_W-4){1'b0}}};
    return {hdr, d, crc_payload(d)};
  endfunction

  // Bit a lane sends at a given bit time: its slice, MSB first.
  function automatic logic lane_bit(input logic [FRAME_W-1:0] f,
                                    input int lane, input int t);
    return f[lane * BIT_TIMES + BIT_TIMES - 1 - t];
  endfunction
endpackage

// File: rtl/rdu_beat_fifo.sv
module rdu_beat_fifo
  import rdu_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  beat_t push_beat,
  input  logic  pop,
  output beat_t head,
  output logic  not_empty,
  output logic  ovf_evt
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  beat_t          mem [DEPTH];
  logic [PW-1:0]  rd_ptr, wr_ptr;
  logic [CW-1:0]  count_q;
  logic           full, do_push, do_pop;

  assign full      = (count_q == FULL_CNT);
  assign not_empty = (count_q != '0);
  assign do_pop    = pop && not_empty;
  assign do_push   = push && (!full || do_pop);
  assign ovf_evt   = push && full && !do_pop;
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= push_beat;
        wr_ptr      <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      end
      if (do_pop) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      count_q <= count_q + 1'b1;
      else if (do_pop && !do_push) count_q <= count_q - 1'b1;
    end
  end

  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_CNT);
  // R10
  drop_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> count_q == FULL_CNT);
endmodule

// File: rtl/rdu_frame_loader.sv
module rdu_frame_loader
  import rdu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               have_beat,
  input  beat_t              head,
  output logic               pop,
  output logic [FRAME_W-1:0] frame_q
);
  logic [1:0]  seq_q, seq_use;
  frame_type_e ft;

  assign pop     = load && have_beat;
  assign seq_use = head.first ? 2'd0 : seq_q;
  assign ft      = head.first ? FT_HEAD : FT_BODY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      seq_q   <= '0;
    end else if (load) begin
      if (have_beat) begin
        frame_q <= pack_frame(ft, seq_use, head.data);
        seq_q   <= seq_use + 2'd1;
      end else begin
        frame_q <= '0;
      end
    end
  end

  // R5
  idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !have_beat) |=> frame_q == '0);
  // R7
  seq_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && head.first) |=> frame_q[FRAME_W-1 -: 4] == {FT_HEAD, 2'b00});
endmodule

// File: rtl/rdu_lane_serializer.sv
module rdu_lane_serializer
  import rdu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] frame_q,
  output logic [LANES-1:0]   lane_bits,
  output logic               at_last,
  output logic               frm_start
);
  localparam int CW = $clog2(BIT_TIMES);
  localparam logic [CW-1:0] LAST_T = CW'(BIT_TIMES - 1);

  logic [CW-1:0] bit_cnt;

  assign at_last   = (bit_cnt == LAST_T);
  assign frm_start = (bit_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       bit_cnt <= '0;
    else if (at_last) bit_cnt <= '0;
    else              bit_cnt <= bit_cnt + 1'b1;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_bits[l] = lane_bit(frame_q, l, int'(bit_cnt));
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !at_last |=> bit_cnt == $past(bit_cnt) + 1'b1);
  // R2
  wrap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> frm_start);
endmodule

// File: rtl/rd_upstream_framer.sv
module rd_upstream_framer
  import rdu_pkg::*;
#(
  parameter int QDEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_vld,
  input  logic             beat_first,
  input  logic [143:0]     beat_data,
  output logic [13:0]      lane_bits,
  output logic             frm_start,
  output logic             frm_idle,
  output logic             ovf_err
);
  beat_t              in_beat, head;
  logic               not_empty, ovf_evt, pop, at_last;
  logic [FRAME_W-1:0] frame_q;
  logic               err_q;

  assign in_beat = '{first: beat_first, data: beat_data};

  rdu_beat_fifo #(.DEPTH(QDEPTH)) u_fifo (
    .clk, .rst_n,
    .push(beat_vld), .push_beat(in_beat), .pop(pop),
    .head(head), .not_empty(not_empty), .ovf_evt(ovf_evt)
  );

  rdu_frame_loader u_load (
    .clk, .rst_n,
    .load(at_last), .have_beat(not_empty), .head(head),
    .pop(pop), .frame_q(frame_q)
  );

  rdu_lane_serializer u_ser (
    .clk, .rst_n,
    .frame_q(frame_q), .lane_bits(lane_bits),
    .at_last(at_last), .frm_start(frm_start)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (ovf_evt) err_q <= 1'b1;
  end

  assign ovf_err  = err_q;
  assign frm_idle = (frame_q[FRAME_W-1 -: 2] == FT_IDLE);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
  // R10
  ovf_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_err);
  // R5
  idle_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_idle |-> lane_bits == '0);
  // R6
  pop_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> frm_start);
endmodule

// File: tb/tb_rd_upstream_framer.sv
module tb_rd_upstream_framer;
  localparam int NL = 14;
  localparam int NT = 12;
  localparam int FW = NL * NT;

  typedef struct packed {
    logic        first;
    logic [31:0] seed;
    logic [1:0]  ftype;
    logic [1:0]  seq;
  } vec_t;

  // R6 / R7: types and sequence numbers expected per beat, incl. wrap 3->0.
  localparam vec_t VECS [9] = '{
    '{1'b1, 32'h1234_0001, 2'd1, 2'd0},
    '{1'b0, 32'hDEAD_BEEF, 2'd2, 2'd1},
    '{1'b0, 32'h0000_0000, 2'd2, 2'd2},
    '{1'b0, 32'hFFFF_FFFF, 2'd2, 2'd3},
    '{1'b1, 32'h8000_0001, 2'd1, 2'd0},
    '{1'b0, 32'h5555_AAAA, 2'd2, 2'd1},
    '{1'b0, 32'h0F0F_F0F0, 2'd2, 2'd2},
    '{1'b0, 32'h7654_3210, 2'd2, 2'd3},
    '{1'b0, 32'hC001_D00D, 2'd2, 2'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          beat_vld = 1'b0;
  logic          beat_first = 1'b0;
  logic [143:0]  beat_data = '0;
  logic [13:0]   lane_bits;
  logic          frm_start, frm_idle, ovf_err;

  int n_checks = 0;
  int n_fails  = 0;
  int idle_cnt = 0;
  bit done     = 1'b0;
  logic [FW-1:0] exp_q [$];

  always #2 clk = ~clk;

  rd_upstream_framer dut (
    .clk, .rst_n, .beat_vld, .beat_first, .beat_data,
    .lane_bits, .frm_start, .frm_idle, .ovf_err
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [143:0] mk_data(input logic [31:0] s);
    return {s, ~s, s ^ 32'hA5A5_5A5A, s + 32'd1, s[15:0]};
  endfunction

  // Remainder of payload * x^16 by long division (R8).
  function automatic logic [15:0] div_crc(input logic [143:0] d);
    logic [159:0] r;
    r = {d, 16'h0000};
    for (int i = 159; i >= 16; i--)
      if (r[i]) r[i -: 17] = r[i -: 17] ^ 17'h1_1021;
    return r[15:0];
  endfunction

  function automatic logic [FW-1:0] mk_frame(input logic [1:0] ft,
                                             input logic [1:0] sq,
                                             input logic [31:0] s);
    logic [143:0] d;
    d = mk_data(s);
    return {ft, sq, 4'h0, d, div_crc(d)};
  endfunction

  // Frame collector: rebuilds each frame from the lanes.
  logic [FW-1:0] cap;
  int  cap_t = 0;
  int  since = 0;
  bit  seen = 1'b0;
  logic idle_seen = 1'b0;

  task automatic finish_frame();
    logic [FW-1:0] e;
    if (cap[FW-1 -: 2] == 2'b00) begin
      idle_cnt++;
      chk(cap == '0, "R5 idle frame all zero", cap, '0);
      chk(idle_seen == 1'b1, "R5 idle flag on idle frame", FW'(idle_seen), FW'(1));
    end else if (exp_q.size() == 0) begin
      chk(1'b0, "R6 unexpected data frame", cap, '0);
    end else begin
      e = exp_q.pop_front();
      chk(cap[FW-1 -: 8] == e[FW-1 -: 8], "R7 header type/seq", FW'(cap[FW-1 -: 8]), FW'(e[FW-1 -: 8]));
      chk(cap[159:16] == e[159:16], "R3 payload via lane mapping", FW'(cap[159:16]), FW'(e[159:16]));
      chk(cap[15:0] == e[15:0], "R8 crc", FW'(cap[15:0]), FW'(e[15:0]));
      chk(idle_seen == 1'b0, "R5 idle flag low on data frame", FW'(idle_seen), '0);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      seen  = 1'b0;
      since = 0;
    end else begin
      since++;
      if (frm_start) begin
        if (seen) chk(since == NT, "R2 frame period", FW'(since), FW'(NT));
        since     = 0;
        seen      = 1'b1;
        cap_t     = 0;
        idle_seen = frm_idle;
      end else if (seen && cap_t == 0) begin
        chk(1'b0, "R2 missing frame start", '0, FW'(1));
      end
      if (seen) begin
        if (frm_idle !== idle_seen) chk(1'b0, "R5 idle flag stable in frame", FW'(frm_idle), FW'(idle_seen));
        for (int l = 0; l < NL; l++) cap[l * NT + NT - 1 - cap_t] = lane_bits[l];
        if (cap_t == NT - 1) begin
          finish_frame();
          cap_t = 0;
        end else begin
          cap_t++;
        end
      end
    end
  end

  task automatic drive_beat(input logic f, input logic [31:0] s);
    beat_vld   = 1'b1;
    beat_first = f;
    beat_data  = mk_data(s);
    @(negedge clk);
    beat_vld   = 1'b0;
    beat_first = 1'b0;
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!frm_start);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    end
  endtask

  initial begin
    int idle_before;
    repeat (2) @(negedge clk);
    // R1: values during reset
    chk(frm_start && frm_idle && lane_bits == '0 && !ovf_err, "R1 during reset",
        FW'({frm_start, frm_idle, ovf_err, lane_bits}), FW'({3'b110, 14'h0}));
    do_reset();
    chk(frm_start && frm_idle && lane_bits == '0 && !ovf_err, "R1 after release",
        FW'({frm_start, frm_idle, ovf_err, lane_bits}), FW'({3'b110, 14'h0}));

    // Vector table walk (R3 R4 R6 R7 R8)
    for (int i = 0; i < 9; i++) begin
      exp_q.push_back(mk_frame(VECS[i].ftype, VECS[i].seq, VECS[i].seed));
      drive_beat(VECS[i].first, VECS[i].seed);
      repeat (NT - 1) @(negedge clk);
    end
    repeat (60) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all table beats sent", FW'(exp_q.size()), '0);

    // R5: idle frames when nothing is pending
    idle_before = idle_cnt;
    repeat (48) @(negedge clk);
    chk(idle_cnt >= idle_before + 3, "R5 idle frames fill gaps", FW'(idle_cnt - idle_before), FW'(3));

    // R9: two beats on consecutive cycles
    wait_start();
    exp_q.push_back(mk_frame(2'd1, 2'd0, 32'hAAAA_0001));
    drive_beat(1'b1, 32'hAAAA_0001);
    exp_q.push_back(mk_frame(2'd2, 2'd1, 32'hAAAA_0002));
    drive_beat(1'b0, 32'hAAAA_0002);
    repeat (60) @(negedge clk);
    chk(exp_q.size() == 0, "R9 both queued beats sent", FW'(exp_q.size()), '0);
    chk(ovf_err == 1'b0, "R9 no error with two waiting", FW'(ovf_err), '0);

    // R10: third beat while two wait is dropped
    wait_start();
    exp_q.push_back(mk_frame(2'd1, 2'd0, 32'hBBBB_0001));
    drive_beat(1'b1, 32'hBBBB_0001);
    exp_q.push_back(mk_frame(2'd2, 2'd1, 32'hBBBB_0002));
    drive_beat(1'b0, 32'hBBBB_0002);
    drive_beat(1'b0, 32'hBBBB_0003);
    chk(ovf_err == 1'b1, "R10 error set on drop", FW'(ovf_err), FW'(1));
    repeat (60) @(negedge clk);
    chk(exp_q.size() == 0, "R10 waiting beats still sent", FW'(exp_q.size()), '0);
    chk(ovf_err == 1'b1, "R10 error sticky", FW'(ovf_err), FW'(1));

    // R10 / R1: reset clears the flag
    do_reset();
    chk(ovf_err == 1'b0 && frm_start, "R10 reset clears error",
        FW'({ovf_err, frm_start}), FW'(2'b01));
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R6 no stray frames", FW'(exp_q.size()), '0);

    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end
endmodule